// File: doc/BRIEF.md
# Dual-Bus X/Y Data Memory Router

This block sits between a 16-bit DSP-style core and its data memory. The memory is split at a fixed boundary into an X region and a Y region, each held in its own bank. The X path has one read port and one write port. It serves every kind of access and sees both regions as a single linear byte-addressed space. The Y path is a read-only second port. It returns data only for the operand prefetch of multiply-accumulate class operations, so two operands can be fetched in the same cycle without a stall.

The core marks a prefetch cycle with a flag and names the pointer register that produced each address. The router enforces ownership. During a prefetch, pointers 8 and 9 may reach only X memory and pointers 10 and 11 may reach only Y memory. A read that breaks this rule returns zero, as does any read of an address outside physical memory. All writes, including accumulator write-back, go over the X path and may land anywhere in either region. The region limits are elaboration parameters and cannot be changed at run time.

Top module: `xy_mem_router`

## Requirements
- R1: While reset is held, both read data outputs are zero. A read issued in one cycle shows its data on the outputs after the next rising clock edge, and not before.
- R2: Outside a prefetch cycle, a word read on the X path returns the stored word at any address in the X region (X_BASE up to X_BASE+2*X_WORDS-1) or in the Y region, which directly follows it (Y_WORDS words). Address bit 0 is ignored for word reads.
- R3: Outside a prefetch cycle with the byte flag set, the X path returns the low byte of the word when address bit 0 is 0 and the high byte when it is 1. The byte is placed in bits 7:0 and bits 15:8 read as zero.
- R4: An X path read of an address outside both regions returns 0x0000. A write to such an address changes no stored word, including the words it would alias to under index truncation.
- R5: A write stores data bits 7:0 when byte-enable bit 0 is set and bits 15:8 when byte-enable bit 1 is set, at any address in either region. An all-zero byte-enable writes nothing.
- R6: In a prefetch cycle, the X path returns data only when its pointer is 8 or 9 and its address is in the X region. Otherwise it returns 0x0000, including an X pointer that lands in the Y region and any other pointer number.
- R7: The Y path returns data only in a prefetch cycle, with pointer 10 or 11 and an address in the Y region. In every other case it returns 0x0000, including a Y pointer that lands in the X region.
- R8: In a prefetch cycle the byte flag is ignored and the X path returns the whole word.
- R9: A Y path read and an X path read in the same cycle both return data after one edge. A read of the word being written in the same cycle returns the old contents, and the new contents appear from the following read on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the read pipeline |
| mac_pf | input | 1 | Current access is a multiply-accumulate operand prefetch |
| xr_addr | input | 16 | X path read byte address |
| xr_byte | input | 1 | X path read is a byte read |
| xr_ptr | input | 4 | Pointer register number behind the X read address |
| xw_en | input | 1 | X path write request |
| xw_addr | input | 16 | X path write byte address |
| xw_data | input | 16 | X path write data |
| xw_be | input | 2 | Write byte enables, bit 0 low byte, bit 1 high byte |
| yr_addr | input | 16 | Y path read byte address |
| yr_ptr | input | 4 | Pointer register number behind the Y read address |
| xr_data | output | 16 | X path read data, one cycle after the request |
| yr_data | output | 16 | Y path read data, one cycle after the request |

## Verification
The assertions assume that reset is low from time zero and that every input is stable around the rising edge. They also assume that the pointer numbers describe the actual source of the addresses, because the block cannot detect a false pointer tag. The bench drives all inputs only on falling edges. It fills every implemented word with a known pattern before it reads anything, so the read checks never see uninitialised storage. Pointer values outside 8 to 11 are used only where a zero result is expected.

// File: rtl/xyr_pkg.sv
package xyr_pkg;

    typedef enum logic [1:0] {
        SPACE_NONE = 2'd0,
        SPACE_X    = 2'd1,
        SPACE_Y    = 2'd2
    } space_e;

    // registered read-control state, carried one cycle alongside the bank read
    typedef struct packed {
        logic x_ok;      // X path result may show memory data
        logic x_from_y;  // X path data comes from the Y bank
        logic x_byte;    // X path returns a single byte
        logic x_hi;      // selected byte is the upper one
        logic y_ok;      // Y path result may show memory data
        logic y_from_y;  // Y path data comes from the Y bank
    } rd_ctl_t;

    localparam logic [3:0] PTR_XA = 4'd8;
    localparam logic [3:0] PTR_XB = 4'd9;
    localparam logic [3:0] PTR_YA = 4'd10;
    localparam logic [3:0] PTR_YB = 4'd11;

endpackage

// File: rtl/xyr_addr_decode.sv
module xyr_addr_decode
    import xyr_pkg::*;
#(
    parameter int unsigned X_BASE  = 32'h0800,
    parameter int unsigned X_WORDS = 512,
    parameter int unsigned Y_WORDS = 512,
    parameter int unsigned IDX_W   = 9
) (
    input  logic [15:0]      addr,
    output space_e           space,
    output logic [IDX_W-1:0] idx
);
    localparam logic [31:0] X_LO = 32'(X_BASE);
    localparam logic [31:0] Y_LO = 32'(X_BASE + 2 * X_WORDS);
    localparam logic [31:0] Y_HI = 32'(X_BASE + 2 * X_WORDS + 2 * Y_WORDS);

    logic [31:0] a32;
    logic [31:0] off;

    always_comb begin
        a32   = {16'h0000, addr};
        space = SPACE_NONE;
        off   = '0;
        if (a32 >= X_LO && a32 < Y_LO) begin
            space = SPACE_X;
            off   = a32 - X_LO;
        end else if (a32 >= Y_LO && a32 < Y_HI) begin
            space = SPACE_Y;
            off   = a32 - Y_LO;
        end
        idx = off[IDX_W:1];
    end

endmodule

// File: rtl/xyr_bank.sv
module xyr_bank #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned IDX_W = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [15:0]      wdata,
    input  logic [1:0]       wbe,
    input  logic [IDX_W-1:0] ra_idx,
    output logic [15:0]      ra_data,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [15:0]      rb_data
);
    logic [15:0] mem [DEPTH];
    logic [15:0] ra_q;
    logic [15:0] rb_q;

    // read-first: the reads see the contents before this edge's write
    always_ff @(posedge clk) begin
        ra_q <= mem[ra_idx];
        rb_q <= mem[rb_idx];
        if (we) begin
            for (int b = 0; b < 2; b++) begin
                if (wbe[b]) mem[widx][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    assign ra_data = ra_q;
    assign rb_data = rb_q;

    AST_BANK_WIDX_RANGE: assert property (@(posedge clk)
        we |-> (32'(widx) < DEPTH)); // R4

endmodule

// File: rtl/xy_mem_router.sv
module xy_mem_router
    import xyr_pkg::*;
#(
    parameter int unsigned X_BASE  = 32'h0800,
    parameter int unsigned X_WORDS = 512,
    parameter int unsigned Y_WORDS = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mac_pf,
    input  logic [15:0] xr_addr,
    input  logic        xr_byte,
    input  logic [3:0]  xr_ptr,
    input  logic        xw_en,
    input  logic [15:0] xw_addr,
    input  logic [15:0] xw_data,
    input  logic [1:0]  xw_be,
    input  logic [15:0] yr_addr,
    input  logic [3:0]  yr_ptr,
    output logic [15:0] xr_data,
    output logic [15:0] yr_data
);
    localparam int unsigned MAX_WORDS = (X_WORDS > Y_WORDS) ? X_WORDS : Y_WORDS;
    localparam int unsigned IDX_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
    localparam int unsigned N_BANK    = 2;

    space_e           xr_space, xw_space, yr_space;
    logic [IDX_W-1:0] xr_idx, xw_idx, yr_idx;

    xyr_addr_decode #(.X_BASE(X_BASE), .X_WORDS(X_WORDS), .Y_WORDS(Y_WORDS), .IDX_W(IDX_W))
        u_dec_xr (.addr(xr_addr), .space(xr_space), .idx(xr_idx));
    xyr_addr_decode #(.X_BASE(X_BASE), .X_WORDS(X_WORDS), .Y_WORDS(Y_WORDS), .IDX_W(IDX_W))
        u_dec_xw (.addr(xw_addr), .space(xw_space), .idx(xw_idx));
    xyr_addr_decode #(.X_BASE(X_BASE), .X_WORDS(X_WORDS), .Y_WORDS(Y_WORDS), .IDX_W(IDX_W))
        u_dec_yr (.addr(yr_addr), .space(yr_space), .idx(yr_idx));

    // bank 0 holds the X region, bank 1 the Y region
    logic [15:0] bank_ra [N_BANK];
    logic [15:0] bank_rb [N_BANK];
    logic        bank_we [N_BANK];

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        localparam int unsigned B_DEPTH = (b == 0) ? X_WORDS : Y_WORDS;
        localparam space_e      B_SPACE = (b == 0) ? SPACE_X : SPACE_Y;

        assign bank_we[b] = xw_en && (xw_space == B_SPACE) && (xw_be != 2'b00);

        xyr_bank #(.DEPTH(B_DEPTH), .IDX_W(IDX_W)) u_bank (
            .clk    (clk),
            .we     (bank_we[b]),
            .widx   (xw_idx),
            .wdata  (xw_data),
            .wbe    (xw_be),
            .ra_idx (xr_idx),
            .ra_data(bank_ra[b]),
            .rb_idx (yr_idx),
            .rb_data(bank_rb[b])
        );
    end

    rd_ctl_t st_d, st_q;
    logic    x_ptr_ok, y_ptr_ok;

    always_comb begin
        x_ptr_ok = (xr_ptr == PTR_XA) || (xr_ptr == PTR_XB);
        y_ptr_ok = (yr_ptr == PTR_YA) || (yr_ptr == PTR_YB);
        st_d          = '0;
        st_d.x_from_y = (xr_space == SPACE_Y);
        st_d.x_hi     = xr_addr[0];
        st_d.y_from_y = (yr_space == SPACE_Y);
        if (mac_pf) begin
            st_d.x_ok   = (xr_space == SPACE_X) && x_ptr_ok;
            st_d.x_byte = 1'b0;
            st_d.y_ok   = (yr_space == SPACE_Y) && y_ptr_ok;
        end else begin
            st_d.x_ok   = (xr_space != SPACE_NONE);
            st_d.x_byte = xr_byte;
            st_d.y_ok   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [15:0] x_word, y_word;

    always_comb begin
        x_word = st_q.x_from_y ? bank_ra[1] : bank_ra[0];
        y_word = st_q.y_from_y ? bank_rb[1] : bank_rb[0];
        if (!st_q.x_ok)       xr_data = 16'h0000;
        else if (st_q.x_byte) xr_data = {8'h00, st_q.x_hi ? x_word[15:8] : x_word[7:0]};
        else                  xr_data = x_word;
        yr_data = st_q.y_ok ? y_word : 16'h0000;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (xr_data == 16'h0000 && yr_data == 16'h0000)); // R1

    AST_X_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (xr_space == SPACE_NONE) |=> (xr_data == 16'h0000)); // R4

    AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!mac_pf && xr_byte) |=> (xr_data[15:8] == 8'h00)); // R3

    AST_XPTR_WRONG_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_pf && xr_space == SPACE_Y) |=> (xr_data == 16'h0000)); // R6

    AST_Y_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_pf |=> (yr_data == 16'h0000)); // R7

    AST_YPTR_WRONG_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_pf && yr_space == SPACE_X) |=> (yr_data == 16'h0000)); // R7

endmodule

// File: tb/xy_mem_router_tb_top.sv
module xy_mem_router_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int unsigned XB = 32'h0800;
    localparam int unsigned XW = 512;
    localparam int unsigned YW = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mac_pf = 1'b0;
    logic [15:0] xr_addr = '0;
    logic        xr_byte = 1'b0;
    logic [3:0]  xr_ptr = '0;
    logic        xw_en = 1'b0;
    logic [15:0] xw_addr = '0;
    logic [15:0] xw_data = '0;
    logic [1:0]  xw_be = '0;
    logic [15:0] yr_addr = '0;
    logic [3:0]  yr_ptr = '0;
    logic [15:0] xr_data, yr_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xy_mem_router #(.X_BASE(XB), .X_WORDS(XW), .Y_WORDS(YW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mac_pf(mac_pf),
        .xr_addr(xr_addr), .xr_byte(xr_byte), .xr_ptr(xr_ptr),
        .xw_en(xw_en), .xw_addr(xw_addr), .xw_data(xw_data), .xw_be(xw_be),
        .yr_addr(yr_addr), .yr_ptr(yr_ptr),
        .xr_data(xr_data), .yr_data(yr_data)
    );

    // kx/ky: 0 = zero, 1 = stored word, 2 = selected byte
    typedef struct packed {
        logic        mac;
        logic        byt;
        logic [15:0] xa;
        logic [3:0]  xp;
        logic [15:0] ya;
        logic [3:0]  yp;
        logic [1:0]  kx;
        logic [1:0]  ky;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 16'h0800, 4'd0,  16'h0C00, 4'd10, 2'd1, 2'd0, 4'd2}, // R2 first X word, R7 idle Y
        '{1'b0, 1'b0, 16'h0BFE, 4'd0,  16'h0C00, 4'd10, 2'd1, 2'd0, 4'd2}, // R2 last X word
        '{1'b0, 1'b0, 16'h0C00, 4'd0,  16'h0C02, 4'd11, 2'd1, 2'd0, 4'd2}, // R2 Y via X path
        '{1'b0, 1'b0, 16'h0FFE, 4'd0,  16'h0C00, 4'd10, 2'd1, 2'd0, 4'd2}, // R2 last Y word
        '{1'b0, 1'b0, 16'h0801, 4'd0,  16'h0C00, 4'd10, 2'd1, 2'd0, 4'd2}, // R2 odd word address
        '{1'b0, 1'b0, 16'h07FE, 4'd0,  16'h0C00, 4'd10, 2'd0, 2'd0, 4'd4}, // R4 below X
        '{1'b0, 1'b0, 16'h1000, 4'd0,  16'h0C00, 4'd10, 2'd0, 2'd0, 4'd4}, // R4 above Y
        '{1'b0, 1'b0, 16'hFFFE, 4'd0,  16'h0C00, 4'd10, 2'd0, 2'd0, 4'd4}, // R4 top of space
        '{1'b0, 1'b1, 16'h0A10, 4'd0,  16'h0C00, 4'd10, 2'd2, 2'd0, 4'd3}, // R3 low byte
        '{1'b0, 1'b1, 16'h0A11, 4'd0,  16'h0C00, 4'd10, 2'd2, 2'd0, 4'd3}, // R3 high byte
        '{1'b0, 1'b1, 16'h0D23, 4'd0,  16'h0C00, 4'd10, 2'd2, 2'd0, 4'd3}, // R3 byte in Y region
        '{1'b1, 1'b0, 16'h0800, 4'd8,  16'h0C00, 4'd10, 2'd1, 2'd1, 4'd9}, // R9 dual fetch
        '{1'b1, 1'b0, 16'h0BFE, 4'd9,  16'h0FFE, 4'd11, 2'd1, 2'd1, 4'd6}, // R6 boundary words
        '{1'b1, 1'b0, 16'h0C00, 4'd8,  16'h0BFE, 4'd10, 2'd0, 2'd0, 4'd6}, // R6 R7 crossed spaces
        '{1'b1, 1'b0, 16'h0900, 4'd10, 16'h0E00, 4'd8,  2'd0, 2'd0, 4'd7}, // R6 R7 swapped pointers
        '{1'b1, 1'b1, 16'h0901, 4'd8,  16'h0E00, 4'd11, 2'd1, 2'd1, 4'd8}, // R8 byte flag ignored
        '{1'b1, 1'b0, 16'h1000, 4'd9,  16'h1000, 4'd11, 2'd0, 2'd0, 4'd4}, // R4 unimplemented prefetch
        '{1'b1, 1'b0, 16'h0800, 4'd3,  16'h0C00, 4'd2,  2'd0, 2'd0, 4'd7}  // R6 R7 other pointers
    };

    function automatic logic [15:0] pat(input logic [15:0] a);
        return {a[15:1], 1'b0} ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] expv(input logic [1:0] k, input logic [15:0] a);
        logic [15:0] w;
        w = pat(a);
        case (k)
            2'd1:    return w;
            2'd2:    return {8'h00, a[0] ? w[15:8] : w[7:0]};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string rq);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
        xw_en = 1'b1; xw_addr = a; xw_data = d; xw_be = be;
        @(negedge clk);
        xw_en = 1'b0; xw_be = 2'b00;
    endtask

    task automatic rd(input logic mac, input logic byt, input logic [15:0] xa, input logic [3:0] xp,
                      input logic [15:0] ya, input logic [3:0] yp);
        mac_pf = mac; xr_byte = byt; xr_addr = xa; xr_ptr = xp; yr_addr = ya; yr_ptr = yp;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(xr_data, 16'h0000, "R1 reset x");
        chk(yr_data, 16'h0000, "R1 reset y");
        rst_n = 1'b1;
        @(negedge clk);

        for (int a = 32'h0800; a < 32'h1000; a += 2) wr(16'(a), pat(16'(a)), 2'b11); // R5 full words

        // R1 latency: no data before the edge, data after it
        mac_pf = 1'b0; xr_byte = 1'b0; xr_addr = 16'h0820;
        #1 chk(xr_data, 16'h0000, "R1 before edge");
        @(negedge clk);
        chk(xr_data, pat(16'h0820), "R1 after edge");

        for (int i = 0; i < NV; i++) begin
            rd(VEC[i].mac, VEC[i].byt, VEC[i].xa, VEC[i].xp, VEC[i].ya, VEC[i].yp);
            chk(xr_data, expv(VEC[i].kx, VEC[i].xa), $sformatf("R%0d vec%0d x", VEC[i].rq, i));
            chk(yr_data, expv(VEC[i].ky, VEC[i].ya), $sformatf("R%0d vec%0d y", VEC[i].rq, i));
        end

        // R5 byte enables
        wr(16'h0844, 16'h1234, 2'b01);
        rd(1'b0, 1'b0, 16'h0844, 4'd0, 16'h0C00, 4'd10);
        chk(xr_data, {pat(16'h0844) >> 8, 8'h34}, "R5 low lane");
        wr(16'h0844, 16'hABCD, 2'b10);
        rd(1'b0, 1'b0, 16'h0844, 4'd0, 16'h0C00, 4'd10);
        chk(xr_data, 16'hAB34, "R5 high lane");
        wr(16'h0844, 16'h0000, 2'b00);
        rd(1'b0, 1'b0, 16'h0844, 4'd0, 16'h0C00, 4'd10);
        chk(xr_data, 16'hAB34, "R5 no lanes");
        wr(16'h0E40, 16'h7E57, 2'b11);
        rd(1'b0, 1'b0, 16'h0E40, 4'd0, 16'h0C00, 4'd10);
        chk(xr_data, 16'h7E57, "R5 write into Y region");

        // R4 dropped writes must not alias
        wr(16'h1000, 16'hFFFF, 2'b11);
        wr(16'h07FE, 16'hFFFF, 2'b11);
        wr(16'h1400, 16'hFFFF, 2'b11);
        rd(1'b0, 1'b0, 16'h0C00, 4'd0, 16'h0C00, 4'd10);
        chk(xr_data, pat(16'h0C00), "R4 no alias Y base");
        rd(1'b0, 1'b0, 16'h0800, 4'd0, 16'h0C00, 4'd10);
        chk(xr_data, pat(16'h0800), "R4 no alias X base");
        rd(1'b0, 1'b0, 16'h0BFE, 4'd0, 16'h0C00, 4'd10);
        chk(xr_data, pat(16'h0BFE), "R4 no alias X top");

        // R9 write and read of the same word in one cycle
        xw_en = 1'b1; xw_addr = 16'h0C40; xw_data = 16'hBEEF; xw_be = 2'b11;
        mac_pf = 1'b1; xr_byte = 1'b0; xr_addr = 16'h0840; xr_ptr = 4'd8;
        yr_addr = 16'h0C40; yr_ptr = 4'd10;
        @(negedge clk);
        xw_en = 1'b0; xw_be = 2'b00;
        chk(yr_data, pat(16'h0C40), "R9 y old data");
        chk(xr_data, pat(16'h0840), "R9 x same cycle");
        @(negedge clk);
        chk(yr_data, 16'hBEEF, "R9 y new data");
        xw_en = 1'b1; xw_addr = 16'h0840; xw_data = 16'hC0DE; xw_be = 2'b11;
        @(negedge clk);
        xw_en = 1'b0; xw_be = 2'b00;
        chk(xr_data, pat(16'h0840), "R9 x old data");
        @(negedge clk);
        chk(xr_data, 16'hC0DE, "R9 x new data");

        // R1 reset again clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk(xr_data, 16'h0000, "R1 re-reset x");
        chk(yr_data, 16'h0000, "R1 re-reset y");
        rst_n = 1'b1;
        mac_pf = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule